// File: doc/BRIEF.md
# LPI wake timer with microsecond tick

This block controls the transmit side of an energy-efficient Ethernet MAC as it leaves low-power idle (LPI). A free-running prescaler divides the register-interface clock down to a one-microsecond reference pulse. Its period is set by a programmable reload value, which is the number of clock cycles in one microsecond minus one. Every LPI timer in the block advances on this pulse and never on raw clock cycles. So if the reload value does not match the real clock, the wake period scales with the error. For example, the reset value of 99 on a 266 MHz clock cuts a 30 µs wake to about 11 µs.

While LPI is requested, the transmit control line is tristated and no frame may leave. When the request drops, the line is driven low for the programmed wake time, counted in microsecond ticks. After that the line is driven high and frames are released again. If LPI is requested again during the wake period, the wake is abandoned and the block returns to LPI.

Frames are offered on a valid/ready pair. The producer holds `frm_valid` high until it sees `frm_ready`, and a frame moves on each cycle where both are high. `frm_ready` is low for the whole of LPI and the wake period, which is the back-pressure that keeps a frame queued until the PHY is ready. An LPI request is not taken in a cycle where a frame is being handed over. Configuration uses a one-cycle write strobe with a one-bit address.

Top module: `lpi_wake_ctrl`

## Requirements
- R1: After reset the block is active: `txc_oe`=1, `txc_o`=1 and `frm_ready`=1. The reload register holds TICK_RST (default 99, meaning a 100 MHz clock) and the wake time register holds WAKE_RST (default 30 µs).
- R2: The microsecond tick comes every reload+1 clock cycles and is one cycle wide. The prescaler counts up from 0 to the reload value and then starts again at 0. A reload of 0 gives a tick on every cycle.
- R3: A write to the reload register takes effect only at the next terminal count, so no tick period is ever shortened by a write.
- R4: An LPI request (`lpi_req`=1) that is taken forces `txc_oe`=0 and `frm_ready`=0 from the next cycle on, for as long as LPI lasts.
- R5: When `lpi_req` falls, the block enters the wake period on the next edge. From then until release, `txc_oe`=1 and `txc_o`=0.
- R6: With wake time W, frames are released (`frm_ready`=1, `txc_o`=1) on the (W+1)-th tick counted after entering the wake period. W ticks therefore always elapse in full, whatever the phase of the prescaler. Counted in edges from the edge that samples `lpi_req`=0, release takes between W·(R+1)+2 and (W+1)·(R+1)+1 edges, where R is the reload value. With R=0 it takes exactly W+2.
- R7: A wake time of 0 releases frames on the first tick after exit.
- R8: An LPI request during the wake period aborts the wake. The line returns to tristate and the next exit starts a full new wake.
- R9: The wake time is captured when LPI is left. A write to the wake time register during a wake period does not change that wake, only later ones.
- R10: `frm_ready` is 1 only in the active state, where it does not depend on `frm_valid`. While `frm_valid`=1 in the active state an LPI request is held off. The request is taken on the first edge where `frm_valid`=0.
- R11: A write with `cfg_addr`=0 loads the reload value from `cfg_wdata[TICK_W-1:0]`. A write with `cfg_addr`=1 loads the wake time from `cfg_wdata[WAKE_W-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0: tick reload, 1: wake time |
| cfg_wdata | input | WAKE_W | Configuration write data |
| lpi_req | input | 1 | 1 requests LPI, 0 requests exit |
| frm_valid | input | 1 | A transmit frame is pending |
| frm_ready | output | 1 | Frame may be released to the PHY |
| txc_o | output | 1 | Transmit control line value |
| txc_oe | output | 1 | Drive enable of the transmit control line (0 = high impedance) |

## Verification
The bench builds the block with TICK_W=6, a reload reset value of 9, WAKE_W=8 and a wake reset value of 3. With these values the reset-default wake lasts only about forty cycles, and a full sweep of reload values 0..5 against wake times 0..5 runs quickly. A reload of 0 makes the tick occur on every cycle, so abort, re-capture and wake-time-zero behaviour can be checked at the exact cycle. For other reload values the measured wake length is checked against the arithmetic bounds of R6, which also show how a wrong reload value shrinks or stretches the wake period.

// File: rtl/lpi_wake_pkg.sv
package lpi_wake_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_LPI    = 2'd1,
    ST_WAKE   = 2'd2
  } wake_state_e;
endpackage

// File: rtl/lpi_cfg_regs.sv
module lpi_cfg_regs #(
  parameter int unsigned TICK_W   = 10,
  parameter int unsigned WAKE_W   = 16,
  parameter int unsigned TICK_RST = 99,
  parameter int unsigned WAKE_RST = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              addr,
  input  logic [WAKE_W-1:0] wdata,
  output logic [TICK_W-1:0] reload_o,
  output logic [WAKE_W-1:0] wake_time_o
);
  // R1 reset values, R11 address decode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_o    <= TICK_W'(TICK_RST);
      wake_time_o <= WAKE_W'(WAKE_RST);
    end else if (we) begin
      if (!addr) reload_o    <= wdata[TICK_W-1:0];
      else       wake_time_o <= wdata;
    end
  end

  a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr) |=> (wake_time_o == $past(wdata)));
endmodule

// File: rtl/lpi_us_prescaler.sv
module lpi_us_prescaler #(
  parameter int unsigned TICK_W   = 10,
  parameter int unsigned TICK_RST = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] reload_i,
  output logic              tick_o
);
  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W-1:0] active_q;   // reload value in force for the current period

  assign tick_o = (cnt_q == active_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= TICK_W'(TICK_RST);
    end else if (tick_o) begin
      cnt_q    <= '0;
      active_q <= reload_i;        // R3: adopt only at terminal count
    end else begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= active_q);
  a_r2_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
  a_r3_adopt_at_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (active_q == $past(reload_i)));
  a_r3_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(active_q));
endmodule

// File: rtl/lpi_wake_fsm.sv
module lpi_wake_fsm
  import lpi_wake_pkg::*;
#(
  parameter int unsigned WAKE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [WAKE_W-1:0] wake_time_i,
  input  logic              lpi_req,
  input  logic              frm_valid,
  output logic              frm_ready,
  output logic              txc_o,
  output logic              txc_oe
);
  wake_state_e       state_q;
  logic [WAKE_W-1:0] wcnt_q;
  logic [WAKE_W-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      wcnt_q  <= '0;
      tgt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_ACTIVE: if (lpi_req && !frm_valid) state_q <= ST_LPI;   // R10
        ST_LPI: if (!lpi_req) begin
          state_q <= ST_WAKE;
          wcnt_q  <= '0;
          tgt_q   <= wake_time_i;                                  // R9 capture
        end
        ST_WAKE: begin
          if (lpi_req) state_q <= ST_LPI;                          // R8 abort
          else if (tick_i) begin
            if (wcnt_q == tgt_q) state_q <= ST_ACTIVE;             // R6/R7
            else                 wcnt_q  <= wcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_ACTIVE;
      endcase
    end
  end

  assign frm_ready = (state_q == ST_ACTIVE);
  assign txc_o     = (state_q == ST_ACTIVE);
  assign txc_oe    = (state_q != ST_LPI);

  a_r4_lpi_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    (lpi_req && !(frm_valid && frm_ready)) |=> (!frm_ready && !txc_oe));
  a_r5_leave_hiz_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc_oe) |-> !txc_o);
  a_r6_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_ready) |-> $past(tick_i));
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE) |-> (wcnt_q <= tgt_q));
  a_r9_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE) |=> ((state_q != ST_WAKE) || $stable(tgt_q)));
  a_r2_no_raw_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAKE) && !tick_i && !lpi_req) |=> $stable(wcnt_q));
endmodule

// File: rtl/lpi_wake_ctrl.sv
module lpi_wake_ctrl #(
  parameter int unsigned TICK_W   = 10,
  parameter int unsigned TICK_RST = 99,
  parameter int unsigned WAKE_W   = 16,
  parameter int unsigned WAKE_RST = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [WAKE_W-1:0] cfg_wdata,
  input  logic              lpi_req,
  input  logic              frm_valid,
  output logic              frm_ready,
  output logic              txc_o,
  output logic              txc_oe
);
  logic [TICK_W-1:0] reload;
  logic [WAKE_W-1:0] wake_time;
  logic              tick;

  lpi_cfg_regs #(
    .TICK_W(TICK_W), .WAKE_W(WAKE_W), .TICK_RST(TICK_RST), .WAKE_RST(WAKE_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .reload_o(reload), .wake_time_o(wake_time)
  );

  lpi_us_prescaler #(.TICK_W(TICK_W), .TICK_RST(TICK_RST)) u_presc (
    .clk(clk), .rst_n(rst_n), .reload_i(reload), .tick_o(tick)
  );

  lpi_wake_fsm #(.WAKE_W(WAKE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wake_time_i(wake_time),
    .lpi_req(lpi_req), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .txc_o(txc_o), .txc_oe(txc_oe)
  );
endmodule

// File: tb/lpi_wake_ctrl_tb.sv
module lpi_wake_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 6;
  localparam int TR = 9;
  localparam int WW = 8;
  localparam int WR = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic          cfg_addr = 1'b0;
  logic [WW-1:0] cfg_wdata = '0;
  logic          lpi_req = 1'b0;
  logic          frm_valid = 1'b0;
  logic          frm_ready, txc_o, txc_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpi_wake_ctrl #(.TICK_W(TW), .TICK_RST(TR), .WAKE_W(WW), .WAKE_RST(WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lpi_req(lpi_req), .frm_valid(frm_valid),
    .frm_ready(frm_ready), .txc_o(txc_o), .txc_oe(txc_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = WW'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_lpi();
    @(negedge clk);
    lpi_req = 1'b1;
    idle(2);
    chk(!txc_oe && !frm_ready, "R4 lpi blanks line", {txc_oe, frm_ready}, 0);
  endtask

  // Drops the LPI request at a negedge and counts edges until frm_ready rises.
  task automatic exit_measure(output int d, output bit drive_bad);
    lpi_req = 1'b0;
    d = 0; drive_bad = 1'b0;
    while (d < 3000) begin
      @(posedge clk); @(negedge clk);
      d++;
      if (frm_ready) break;
      if (!(txc_oe && !txc_o)) drive_bad = 1'b1;
    end
  endtask

  initial begin
    int d;
    bit bad;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk(frm_ready && txc_oe && txc_o, "R1 reset active", {frm_ready, txc_oe, txc_o}, 7);

    // R1: defaults reload TR, wake WR
    idle(15);
    enter_lpi();
    exit_measure(d, bad);
    chk(d >= WR*(TR+1)+2 && d <= (WR+1)*(TR+1)+1, "R1 default wake length", d, WR*(TR+1)+2);
    chk(txc_o && txc_oe, "R1 line high after wake", {txc_o, txc_oe}, 3);

    // R2/R5/R6/R7 sweep
    for (int r = 0; r <= 5; r++) begin
      for (int w = 0; w <= 5; w++) begin
        wr(1'b0, r);
        wr(1'b1, w);
        idle(25);
        enter_lpi();
        exit_measure(d, bad);
        if (r == 0)
          chk(d == w + 2, (w == 0) ? "R7 zero wake exact" : "R2 unit tick exact", d, w + 2);
        else
          chk(d >= w*(r+1)+2 && d <= (w+1)*(r+1)+1, "R6 wake bounds", d, w*(r+1)+2);
        chk(!bad, "R5 low during wake", int'(bad), 0);
      end
    end

    // R3: reload change in LPI, then exit at once
    wr(1'b0, 9); wr(1'b1, 3); idle(25);
    enter_lpi();
    wr(1'b0, 1);
    exit_measure(d, bad);
    chk(d >= 8 && d <= 17, "R3 reload at terminal count", d, 8);

    // R11: address 1 sets wake time only
    wr(1'b0, 0); wr(1'b1, 5); idle(25);
    enter_lpi();
    exit_measure(d, bad);
    chk(d == 7, "R11 address decode", d, 7);

    // R8: abort during wake, then full fresh wake
    wr(1'b1, 10); idle(5);
    enter_lpi();
    lpi_req = 1'b0;
    idle(3);
    chk(txc_oe && !txc_o && !frm_ready, "R5 waking", {txc_oe, txc_o, frm_ready}, 4);
    lpi_req = 1'b1;
    idle(1);
    chk(!txc_oe && !frm_ready, "R8 abort to tristate", {txc_oe, frm_ready}, 0);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 20; i++) begin
        idle(1);
        if (frm_ready || txc_oe) seen = 1'b1;
      end
      chk(!seen, "R8 stays in lpi", int'(seen), 0);
    end
    exit_measure(d, bad);
    chk(d == 12, "R8 fresh wake after abort", d, 12);

    // R9: write during wake ignored for that wake, used for the next
    wr(1'b1, 4); idle(5);
    enter_lpi();
    lpi_req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = WW'(40);
    d = 1;
    while (d < 3000) begin
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      d++;
      if (frm_ready) break;
    end
    chk(d == 6, "R9 wake captured at exit", d, 6);
    enter_lpi();
    exit_measure(d, bad);
    chk(d == 42, "R9 new wake time next exit", d, 42);

    // R10: pending frame holds off LPI entry
    wr(1'b1, 0); idle(3);
    @(negedge clk);
    frm_valid = 1'b1; lpi_req = 1'b1;
    idle(3);
    chk(frm_ready && txc_oe, "R10 entry deferred by frame", {frm_ready, txc_oe}, 3);
    frm_valid = 1'b0;
    idle(1);
    chk(!frm_ready && !txc_oe, "R10 entry after frame", {frm_ready, txc_oe}, 0);
    frm_valid = 1'b1;
    idle(4);
    chk(!frm_ready, "R10 frame held in lpi", int'(frm_ready), 0);
    exit_measure(d, bad);
    chk(d == 2 && frm_ready, "R10 frame released after wake", d, 2);
    frm_valid = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule